// File: doc/BRIEF.md
# Branch Target and Next-PC Unit

This block decides where an 8-bit microcontroller core fetches next. Every cycle it takes the address of the instruction that follows the current one, plus a branch class code and the operands a branch may need. From these it forms the next program counter and says whether control flow was redirected. The operands are a page-absolute target, a long target, a signed relative offset, the accumulator, the 16-bit data pointer, a pair of compare operands, a loop counter, a tested bit and the carry flag.

Conditional branches are fused with their side operations, so the unit also returns write-back values. For decrement-and-branch it returns the decremented counter. For test-and-clear it returns the cleared bit. For compare-and-branch it returns a borrow-style carry. The core's fetch, decode, stack handling and interrupt return logic sit outside. The program counter register inside the unit loads the computed next address on every rising clock edge and clears to 0x0000 on a synchronous reset.

Top module: `branch_nextpc`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0x0000. At every other rising edge, `pc` loads the value `next_pc` had just before that edge.
- R2: The class codes on `cls` are: 0 sequential, 1 page-absolute, 2 long, 3 short relative, 4 indirect (A + data pointer), 5 branch if accumulator zero, 6 branch if accumulator nonzero, 7 branch if carry, 8 branch if no carry, 9 branch if bit set, 10 branch if bit clear, 11 bit test-and-clear, 12 compare-and-branch, 13 decrement-and-branch. Codes 14 and 15 behave as 0. Whenever `taken` is 0, `next_pc` equals `seq_pc`.
- R3: Class 1 is always taken. Its `next_pc` is `seq_pc[15:11]` concatenated with `page_tgt[10:0]`, so the target stays inside the 2 KB page of the following instruction.
- R4: Class 2 is always taken, and `next_pc` equals `long_tgt`.
- R5: Class 3, and any taken branch of classes 5 to 13, go to `seq_pc` plus the sign-extended `rel_ofs` (range -128..+127), wrapped modulo 2^16.
- R6: Class 4 is always taken. Its `next_pc` is the zero-extended `acc` plus `dptr`, modulo 2^16.
- R7: Classes 5 and 6 test all 8 bits of `acc`. Class 5 is taken only when `acc` is 0x00, and class 6 only when it is not.
- R8: Class 7 is taken when `carry_in` is 1, and class 8 when it is 0.
- R9: Class 9 is taken when `bit_in` is 1, and class 10 when it is 0. For every class except 11, `bit_out` equals `bit_in`.
- R10: Class 11 is taken when `bit_in` is 1, and `bit_out` is 0 in all cases.
- R11: Class 12 is taken when `cmp_a` differs from `cmp_b`. `cmp_carry` is 1 when `cmp_a` is unsigned-less than `cmp_b`. For every other class, `cmp_carry` is 0.
- R12: For class 13, `cnt_out` is `cnt_in` minus 1 modulo 256, and the branch is taken only when that result is nonzero. For every other class, `cnt_out` equals `cnt_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cls | input | 4 | Branch class code |
| seq_pc | input | 16 | Address of the following instruction |
| page_tgt | input | 11 | Page-absolute target |
| long_tgt | input | 16 | Long target |
| rel_ofs | input | 8 | Signed relative offset |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| cmp_a | input | 8 | First compare operand |
| cmp_b | input | 8 | Second compare operand |
| cnt_in | input | 8 | Loop counter before decrement |
| bit_in | input | 1 | Tested bit |
| carry_in | input | 1 | Carry flag |
| next_pc | output | 16 | Computed next program counter |
| taken | output | 1 | Control flow redirected |
| cnt_out | output | 8 | Counter write-back value |
| bit_out | output | 1 | Tested-bit write-back value |
| cmp_carry | output | 1 | Unsigned less-than result of compare |
| pc | output | 16 | Program counter register |

## Verification
The checker watches several properties on every cycle. It confirms that the PC register follows `next_pc` and that a fall-through always lands on `seq_pc`. It confirms that page and long targets keep the bits they must, that equal compare operands never branch, and that test-and-clear always returns a zero bit. It also covers the counter corners where 1 becomes 0 and 0 becomes 0xFF. The sign extension and wraparound of relative and indirect targets appear only in the bench's scenarios, as do the all-bits accumulator test and the pass-through of write-back values for unrelated classes.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

   typedef enum logic [3:0] {
      BR_SEQ   = 4'd0,
      BR_PAGE  = 4'd1,
      BR_LONG  = 4'd2,
      BR_SHORT = 4'd3,
      BR_IND   = 4'd4,
      BR_ACCZ  = 4'd5,
      BR_ACCNZ = 4'd6,
      BR_CY    = 4'd7,
      BR_NCY   = 4'd8,
      BR_BSET  = 4'd9,
      BR_BCLR  = 4'd10,
      BR_BTCLR = 4'd11,
      BR_CMPNE = 4'd12,
      BR_DECNZ = 4'd13
   } br_cls_e;

   typedef enum logic [2:0] {
      SEL_SEQ  = 3'd0,
      SEL_PAGE = 3'd1,
      SEL_LONG = 3'd2,
      SEL_REL  = 3'd3,
      SEL_IND  = 3'd4
   } tgt_sel_e;

endpackage

// File: rtl/bnpc_target.sv
module bnpc_target #(
   parameter int PC_W   = 16,
   parameter int PAGE_W = 11,
   parameter int DATA_W = 8
) (
   input  logic [PC_W-1:0]   seq_pc,
   input  logic [PAGE_W-1:0] page_tgt,
   input  logic [DATA_W-1:0] rel_ofs,
   input  logic [DATA_W-1:0] acc,
   input  logic [PC_W-1:0]   dptr,
   output logic [PC_W-1:0]   page_pc,
   output logic [PC_W-1:0]   rel_pc,
   output logic [PC_W-1:0]   ind_pc
);

   localparam int EXT_W = PC_W - DATA_W;

   logic [PC_W-1:0] ofs_ext;
   logic [PC_W-1:0] acc_ext;

   generate
      if (PAGE_W < PC_W) begin : g_page_split
         assign page_pc = {seq_pc[PC_W-1:PAGE_W], page_tgt};
      end else begin : g_page_full
         assign page_pc = page_tgt[PC_W-1:0];
      end

      if (EXT_W > 0) begin : g_widen
         assign ofs_ext = {{EXT_W{rel_ofs[DATA_W-1]}}, rel_ofs};
         assign acc_ext = {{EXT_W{1'b0}}, acc};
      end else begin : g_same
         assign ofs_ext = rel_ofs[PC_W-1:0];
         assign acc_ext = acc[PC_W-1:0];
      end
   endgenerate

   assign rel_pc = seq_pc + ofs_ext;
   assign ind_pc = dptr + acc_ext;

endmodule

// File: rtl/bnpc_cond.sv
module bnpc_cond
   import bnpc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [3:0]        cls,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] cmp_a,
   input  logic [DATA_W-1:0] cmp_b,
   input  logic [DATA_W-1:0] cnt_in,
   input  logic              bit_in,
   input  logic              carry_in,
   output logic              taken,
   output tgt_sel_e          sel,
   output logic [DATA_W-1:0] cnt_out,
   output logic              bit_out,
   output logic              cmp_carry
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [DATA_W-1:0] dec_val;
   logic              cond_hit;
   logic              is_cond;

   assign dec_val = cnt_in - ONE;

   always_comb begin
      cond_hit  = 1'b0;
      is_cond   = 1'b0;
      cnt_out   = cnt_in;
      bit_out   = bit_in;
      cmp_carry = 1'b0;
      sel       = SEL_SEQ;
      unique case (cls)
         BR_PAGE:  sel = SEL_PAGE;
         BR_LONG:  sel = SEL_LONG;
         BR_SHORT: sel = SEL_REL;
         BR_IND:   sel = SEL_IND;
         BR_ACCZ: begin
            is_cond  = 1'b1;
            cond_hit = ~|acc;
         end
         BR_ACCNZ: begin
            is_cond  = 1'b1;
            cond_hit = |acc;
         end
         BR_CY: begin
            is_cond  = 1'b1;
            cond_hit = carry_in;
         end
         BR_NCY: begin
            is_cond  = 1'b1;
            cond_hit = ~carry_in;
         end
         BR_BSET: begin
            is_cond  = 1'b1;
            cond_hit = bit_in;
         end
         BR_BCLR: begin
            is_cond  = 1'b1;
            cond_hit = ~bit_in;
         end
         BR_BTCLR: begin
            is_cond  = 1'b1;
            cond_hit = bit_in;
            bit_out  = 1'b0;
         end
         BR_CMPNE: begin
            is_cond   = 1'b1;
            cond_hit  = (cmp_a != cmp_b);
            cmp_carry = (cmp_a < cmp_b);
         end
         BR_DECNZ: begin
            is_cond  = 1'b1;
            cnt_out  = dec_val;
            cond_hit = |dec_val;
         end
         default: sel = SEL_SEQ;
      endcase
      if (is_cond && cond_hit) begin
         sel = SEL_REL;
      end
      taken = (sel != SEL_SEQ);
   end

endmodule

// File: rtl/branch_nextpc.sv
module branch_nextpc
   import bnpc_pkg::*;
#(
   parameter int PC_W   = 16,
   parameter int PAGE_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [3:0]        cls,
   input  logic [PC_W-1:0]   seq_pc,
   input  logic [PAGE_W-1:0] page_tgt,
   input  logic [PC_W-1:0]   long_tgt,
   input  logic [DATA_W-1:0] rel_ofs,
   input  logic [DATA_W-1:0] acc,
   input  logic [PC_W-1:0]   dptr,
   input  logic [DATA_W-1:0] cmp_a,
   input  logic [DATA_W-1:0] cmp_b,
   input  logic [DATA_W-1:0] cnt_in,
   input  logic              bit_in,
   input  logic              carry_in,
   output logic [PC_W-1:0]   next_pc,
   output logic              taken,
   output logic [DATA_W-1:0] cnt_out,
   output logic              bit_out,
   output logic              cmp_carry,
   output logic [PC_W-1:0]   pc
);

   localparam logic [PC_W-1:0] PC_RST = '0;

   generate
      if (PAGE_W > PC_W) begin : g_bad_page
         $error("page target wider than program counter");
      end
      if (DATA_W > PC_W) begin : g_bad_data
         $error("data width wider than program counter");
      end
      if (DATA_W < 2) begin : g_bad_small
         $error("data width too small for signed offset");
      end
   endgenerate

   logic [PC_W-1:0] page_pc;
   logic [PC_W-1:0] rel_pc;
   logic [PC_W-1:0] ind_pc;
   tgt_sel_e        sel;

   bnpc_target #(
      .PC_W   (PC_W),
      .PAGE_W (PAGE_W),
      .DATA_W (DATA_W)
   ) u_target (
      .seq_pc   (seq_pc),
      .page_tgt (page_tgt),
      .rel_ofs  (rel_ofs),
      .acc      (acc),
      .dptr     (dptr),
      .page_pc  (page_pc),
      .rel_pc   (rel_pc),
      .ind_pc   (ind_pc)
   );

   bnpc_cond #(
      .DATA_W (DATA_W)
   ) u_cond (
      .cls       (cls),
      .acc       (acc),
      .cmp_a     (cmp_a),
      .cmp_b     (cmp_b),
      .cnt_in    (cnt_in),
      .bit_in    (bit_in),
      .carry_in  (carry_in),
      .taken     (taken),
      .sel       (sel),
      .cnt_out   (cnt_out),
      .bit_out   (bit_out),
      .cmp_carry (cmp_carry)
   );

   always_comb begin
      unique case (sel)
         SEL_PAGE: next_pc = page_pc;
         SEL_LONG: next_pc = long_tgt;
         SEL_REL:  next_pc = rel_pc;
         SEL_IND:  next_pc = ind_pc;
         default:  next_pc = seq_pc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc <= PC_RST;
      end else begin
         pc <= next_pc;
      end
   end

endmodule

// File: rtl/bnpc_chk.sv
module bnpc_chk
   import bnpc_pkg::*;
#(
   parameter int PC_W   = 16,
   parameter int PAGE_W = 11,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [3:0]        cls,
   input logic [PC_W-1:0]   seq_pc,
   input logic [PAGE_W-1:0] page_tgt,
   input logic [PC_W-1:0]   long_tgt,
   input logic [DATA_W-1:0] cmp_a,
   input logic [DATA_W-1:0] cmp_b,
   input logic [DATA_W-1:0] cnt_in,
   input logic [PC_W-1:0]   next_pc,
   input logic              taken,
   input logic [DATA_W-1:0] cnt_out,
   input logic              bit_out,
   input logic [PC_W-1:0]   pc
);

   // R1
   rst_clear_chk: assert property (@(posedge clk) $past(rst) |-> (pc == '0));

   // R1
   pc_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (pc == $past(next_pc)));

   // R2
   fall_through_chk: assert property (@(posedge clk) disable iff (rst)
      !taken |-> (next_pc == seq_pc));

   // R3
   page_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (cls == BR_PAGE) |-> (taken && next_pc[PAGE_W-1:0] == page_tgt
                            && next_pc[PC_W-1:PAGE_W] == seq_pc[PC_W-1:PAGE_W]));

   // R4
   long_load_chk: assert property (@(posedge clk) disable iff (rst)
      (cls == BR_LONG) |-> (taken && next_pc == long_tgt));

   // R10
   btclr_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (cls == BR_BTCLR) |-> !bit_out);

   // R11
   cmp_equal_chk: assert property (@(posedge clk) disable iff (rst)
      (cls == BR_CMPNE && cmp_a == cmp_b) |-> !taken);

   // R12
   dec_last_chk: assert property (@(posedge clk) disable iff (rst)
      (cls == BR_DECNZ && cnt_in == DATA_W'(1)) |-> (!taken && cnt_out == '0));

   // R12
   dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (cls == BR_DECNZ && cnt_in == '0) |-> (taken && (&cnt_out)));

endmodule

bind branch_nextpc bnpc_chk #(
   .PC_W   (PC_W),
   .PAGE_W (PAGE_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cls      (cls),
   .seq_pc   (seq_pc),
   .page_tgt (page_tgt),
   .long_tgt (long_tgt),
   .cmp_a    (cmp_a),
   .cmp_b    (cmp_b),
   .cnt_in   (cnt_in),
   .next_pc  (next_pc),
   .taken    (taken),
   .cnt_out  (cnt_out),
   .bit_out  (bit_out),
   .pc       (pc)
);

// File: tb/branch_nextpc_bench.sv
module branch_nextpc_bench;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [15:0] pc;
      logic        tk;
      logic [7:0]  cnt;
      logic        bo;
      logic        cy;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  cls = 4'd0;
   logic [15:0] seq_pc = 16'h0;
   logic [10:0] page_tgt = 11'h0;
   logic [15:0] long_tgt = 16'h0;
   logic [7:0]  rel_ofs = 8'h0;
   logic [7:0]  acc = 8'h0;
   logic [15:0] dptr = 16'h0;
   logic [7:0]  cmp_a = 8'h0;
   logic [7:0]  cmp_b = 8'h0;
   logic [7:0]  cnt_in = 8'h0;
   logic        bit_in = 1'b0;
   logic        carry_in = 1'b0;
   logic [15:0] next_pc;
   logic        taken;
   logic [7:0]  cnt_out;
   logic        bit_out;
   logic        cmp_carry;
   logic [15:0] pc;

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   branch_nextpc u_branch_nextpc (
      .clk       (clk),
      .rst       (rst),
      .cls       (cls),
      .seq_pc    (seq_pc),
      .page_tgt  (page_tgt),
      .long_tgt  (long_tgt),
      .rel_ofs   (rel_ofs),
      .acc       (acc),
      .dptr      (dptr),
      .cmp_a     (cmp_a),
      .cmp_b     (cmp_b),
      .cnt_in    (cnt_in),
      .bit_in    (bit_in),
      .carry_in  (carry_in),
      .next_pc   (next_pc),
      .taken     (taken),
      .cnt_out   (cnt_out),
      .bit_out   (bit_out),
      .cmp_carry (cmp_carry),
      .pc        (pc)
   );

   // Expected values follow the requirement text, one class at a time.
   task automatic push(input string tag);
      exp_t        e;
      logic        hit;
      logic [15:0] rel;
      rel   = seq_pc + {{8{rel_ofs[7]}}, rel_ofs};
      e.cnt = cnt_in;
      e.bo  = bit_in;
      e.cy  = 1'b0;
      e.tk  = 1'b0;
      e.pc  = seq_pc;
      hit   = 1'b0;
      case (cls)
         4'd1: begin e.tk = 1'b1; e.pc = {seq_pc[15:11], page_tgt}; end
         4'd2: begin e.tk = 1'b1; e.pc = long_tgt; end
         4'd3: begin e.tk = 1'b1; e.pc = rel; end
         4'd4: begin e.tk = 1'b1; e.pc = dptr + {8'h00, acc}; end
         4'd5: hit = (acc == 8'h00);
         4'd6: hit = (acc != 8'h00);
         4'd7: hit = carry_in;
         4'd8: hit = !carry_in;
         4'd9: hit = bit_in;
         4'd10: hit = !bit_in;
         4'd11: begin hit = bit_in; e.bo = 1'b0; end
         4'd12: begin hit = (cmp_a != cmp_b); e.cy = (cmp_a < cmp_b); end
         4'd13: begin e.cnt = cnt_in - 8'd1; hit = (e.cnt != 8'h00); end
         default: ;
      endcase
      if (hit) begin
         e.tk = 1'b1;
         e.pc = rel;
      end
      if (rst) e.pc = 16'h0000;
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic step(input logic [3:0] c, input string tag);
      cls = c;
      push(tag);
      @(negedge clk);
   endtask

   // Monitor: pc shows the result one edge after the inputs were applied.
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_cmp++;
         if (pc !== e.pc || taken !== e.tk || cnt_out !== e.cnt ||
             bit_out !== e.bo || cmp_carry !== e.cy) begin
            n_bad++;
            $display("FAIL %s: pc=%h tk=%b cnt=%h bit=%b cy=%b expected pc=%h tk=%b cnt=%h bit=%b cy=%b",
                     e.tag, pc, taken, cnt_out, bit_out, cmp_carry,
                     e.pc, e.tk, e.cnt, e.bo, e.cy);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R1 reset clears pc
      rst = 1'b1; seq_pc = 16'h1234; cnt_in = 8'h33;
      step(4'd0, "R1 reset");
      rst = 1'b0;
      // R2 sequential and undefined codes
      seq_pc = 16'h0102;
      step(4'd0, "R2 sequential");
      seq_pc = 16'h7777;
      step(4'd14, "R2 code 14");
      // R3 page-absolute
      seq_pc = 16'h2FFE; page_tgt = 11'h7AB;
      step(4'd1, "R3 page mid");
      seq_pc = 16'hF801; page_tgt = 11'h005;
      step(4'd1, "R3 page top");
      // R4 long
      long_tgt = 16'hBEEF;
      step(4'd2, "R4 long");
      // R5 relative, negative wrap and max forward
      seq_pc = 16'h0010; rel_ofs = 8'h80;
      step(4'd3, "R5 rel back wrap");
      seq_pc = 16'h1000; rel_ofs = 8'h7F;
      step(4'd3, "R5 rel forward");
      // R6 indirect
      acc = 8'hFF; dptr = 16'hFFF0;
      step(4'd4, "R6 ind wrap");
      acc = 8'h80; dptr = 16'h0100;
      step(4'd4, "R6 ind zero-ext");
      // R7 accumulator tests
      seq_pc = 16'h0200; rel_ofs = 8'hF0; acc = 8'h80;
      step(4'd5, "R7 accz msb set");
      acc = 8'h00;
      step(4'd5, "R7 accz zero");
      acc = 8'h01;
      step(4'd6, "R7 accnz lsb");
      acc = 8'h00;
      step(4'd6, "R7 accnz zero");
      // R8 carry tests
      carry_in = 1'b1; rel_ofs = 8'h05;
      step(4'd7, "R8 carry set");
      step(4'd8, "R8 nocarry set");
      carry_in = 1'b0;
      step(4'd8, "R8 nocarry clear");
      // R9 bit tests
      bit_in = 1'b1;
      step(4'd9, "R9 bitset one");
      step(4'd10, "R9 bitclr one");
      bit_in = 1'b0;
      step(4'd10, "R9 bitclr zero");
      // R10 test-and-clear
      bit_in = 1'b1;
      step(4'd11, "R10 btclr one");
      bit_in = 1'b0;
      step(4'd11, "R10 btclr zero");
      // R11 compare
      cmp_a = 8'd5; cmp_b = 8'd5;
      step(4'd12, "R11 cmp equal");
      cmp_a = 8'd3; cmp_b = 8'd200;
      step(4'd12, "R11 cmp less");
      cmp_a = 8'd200; cmp_b = 8'd3;
      step(4'd12, "R11 cmp greater");
      step(4'd3, "R11 carry idle");
      // R12 decrement
      cnt_in = 8'd1;
      step(4'd13, "R12 dec to zero");
      cnt_in = 8'd0;
      step(4'd13, "R12 dec wrap");
      cnt_in = 8'd5;
      step(4'd13, "R12 dec five");
      step(4'd9, "R12 cnt passthru");
      // R1 reset again mid-run
      rst = 1'b1;
      step(4'd2, "R1 reset again");
      rst = 1'b0;
      step(4'd0, "R1 resume");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule